// File: doc/BRIEF.md
# Silence-Duration Thermometer Amplitude Encoder

This block turns the length of a carrier-free interval into a stimulation amplitude. While the silence level is high, the block counts timing ticks. Every fixed number of ticks it turns on one more stage of an eight-stage thermometer code. Each stage enables one unit current source, so the code sets the output current in equal steps up to full scale.

When the silence level drops, the carrier has returned. The live stages then clear at once, without stepping down one stage at a time. A latch strobe freezes the code that had built up into a holding register. That held code and its stage count drive the current DAC until the next strobe. The design is fully synchronous: a tick input marks elapsed time, and the step length is set in ticks.

Top module: `silence_therm_enc`

## Requirements
- R1: After reset, therm_o is 0 and count_o is 0.
- R2: A tick is counted at a clock edge when tick_i and start_i are both high at that edge. While start_i stays high, every STEP_TICKS counted ticks set one more stage. The live code after k counted ticks has its lowest min(N_STAGES, k / STEP_TICKS) bits set.
- R3: The live code saturates at all N_STAGES stages set (8'hFF by default), however long start_i stays high.
- R4: An interval with fewer than STEP_TICKS counted ticks gives an all-zero code.
- R5: A clock edge with start_i low clears every live stage and restarts the tick count. A later interval therefore counts from zero.
- R6: At an edge where latch_i is high, the holding register takes the live code as it stood just before that edge. This holds even if start_i falls at that edge or a tick is counted at that edge. therm_o shows the new value from that edge onward.
- R7: Without latch_i, therm_o keeps its value whatever start_i and tick_i do. Only reset clears it.
- R8: therm_o is always a valid thermometer code: bit k set implies bit k-1 set, with stage 0 at bit 0. count_o always equals the number of set bits of therm_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick, one clock wide |
| start_i | input | 1 | Silence level; high while no carrier is present |
| latch_i | input | 1 | Strobe that captures the live code |
| therm_o | output | 8 | Held thermometer code, bit 0 is the first stage |
| count_o | output | 4 | Number of set stages in therm_o |

## Verification
Directed intervals check specific tick counts. One falls just short of a step boundary and one lands exactly on it, which separates an off-by-one in the step count from correct stepping. A very long interval shows saturation, and a zero-length interval gives an empty code. One sequence drops the silence level briefly between two intervals; leftover count or stages would show up in the second capture. Another strobes while a step completes at the same edge, which separates capture of the pre-edge code from the post-edge code. Random intervals with random tick density and length are compared against a bench model of ticks divided by step length, and the held output is watched for changes between strobes.

// File: rtl/silence_therm_pkg.sv
`timescale 1ns/1ps
package silence_therm_pkg;
  localparam int unsigned DEF_STAGES = 8;
  localparam int unsigned DEF_STEP_TICKS = 10;
endpackage

// File: rtl/step_timer.sv
`timescale 1ns/1ps
module step_timer #(
  parameter int unsigned STEP_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic full_i,
  output logic step_o
);
  localparam int unsigned CW = $clog2(STEP_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEP_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          adv;

  assign adv    = run_i & tick_i & ~full_i;
  assign step_o = adv & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/therm_chain.sv
`timescale 1ns/1ps
module therm_chain #(
  parameter int unsigned N_STAGES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                step_i,
  output logic [N_STAGES-1:0] stages_o,
  output logic                full_o
);
  logic [N_STAGES-1:0] stages_q;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    logic prev_set;
    if (k == 0) begin : g_first
      assign prev_set = 1'b1;
    end else begin : g_next
      assign prev_set = stages_q[k-1];
    end
    // slow rise on a step, fast clear when silence ends
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               stages_q[k] <= 1'b0;
      else if (!run_i)           stages_q[k] <= 1'b0;
      else if (step_i && prev_set) stages_q[k] <= 1'b1;
    end
  end

  assign stages_o = stages_q;
  assign full_o   = stages_q[N_STAGES-1];

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> stages_q == '0);

  p_one_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $countones(stages_q) <= $countones($past(stages_q)) + 1);

  p_saturate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && stages_q[N_STAGES-1]) |=> $stable(stages_q));

  p_valid_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stages_q & (stages_q + 1'b1)) == '0);
endmodule

// File: rtl/code_hold.sv
`timescale 1ns/1ps
module code_hold #(
  parameter int unsigned N_STAGES = 8,
  localparam int unsigned CNTW = $clog2(N_STAGES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                latch_i,
  input  logic [N_STAGES-1:0] live_i,
  output logic [N_STAGES-1:0] code_o,
  output logic [CNTW-1:0]     count_o
);
  logic [N_STAGES-1:0] code_q;
  logic [CNTW-1:0]     ones;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (latch_i) code_q <= live_i;
  end

  always_comb begin
    ones = '0;
    for (int k = 0; k < N_STAGES; k++) ones = ones + CNTW'(code_q[k]);
  end

  assign code_o  = code_q;
  assign count_o = ones;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(code_q));

  p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> code_q == $past(live_i));

  p_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_o) == $countones(code_o));
endmodule

// File: rtl/silence_therm_enc.sv
`timescale 1ns/1ps
module silence_therm_enc
  import silence_therm_pkg::*;
#(
  parameter int unsigned N_STAGES   = DEF_STAGES,
  parameter int unsigned STEP_TICKS = DEF_STEP_TICKS,
  localparam int unsigned CNTW = $clog2(N_STAGES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic                latch_i,
  output logic [N_STAGES-1:0] therm_o,
  output logic [CNTW-1:0]     count_o
);
  logic                step;
  logic                full;
  logic [N_STAGES-1:0] live;

  step_timer #(.STEP_TICKS(STEP_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (start_i),
    .full_i (full),
    .step_o (step)
  );

  therm_chain #(.N_STAGES(N_STAGES)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (start_i),
    .step_i   (step),
    .stages_o (live),
    .full_o   (full)
  );

  code_hold #(.N_STAGES(N_STAGES)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .latch_i (latch_i),
    .live_i  (live),
    .code_o  (therm_o),
    .count_o (count_o)
  );

  p_valid_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_o & (therm_o + 1'b1)) == '0);
endmodule

// File: tb/sim_silence_therm_enc.sv
`timescale 1ns/1ps
module sim_silence_therm_enc;
  localparam int N = 8;
  localparam int STEP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, latch = 1'b0;
  logic [7:0] therm;
  logic [3:0] cnt;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int mticks = 0;
  logic [7:0] exp_code = '0;
  bit done = 0;

  always #4 clk = ~clk;

  silence_therm_enc u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .latch_i(latch), .therm_o(therm), .count_o(cnt)
  );

  function automatic logic [7:0] therm_of(input int ticks);
    int lv = ticks / STEP;
    if (lv > N) lv = N;
    return (lv == 0) ? 8'h00 : 8'((16'h1 << lv) - 1);
  endfunction

  function automatic int ones_of(input logic [7:0] v);
    int c = 0;
    for (int k = 0; k < 8; k++) c += int'(v[k]);
    return c;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    chk(req, therm, exp_code);
    chk("R8 count", 8'(cnt), 8'(ones_of(exp_code)));
    chk("R8 shape", therm & (therm + 8'h1), 8'h00);
  endtask

  // drive for one edge and update the model for that edge
  task automatic cyc_drive(input logic s, input logic t, input logic l);
    @(negedge clk);
    start = s; tick = t; latch = l;
    if (l) exp_code = therm_of(mticks);
    if (!s) mticks = 0;
    else if (t) mticks++;
  endtask

  task automatic run_interval(input int ticks, input int gap_pct);
    int got = 0;
    while (got < ticks) begin
      if (int'($urandom % 100) < gap_pct) cyc_drive(1, 0, 0);
      else begin cyc_drive(1, 1, 0); got++; end
    end
  endtask

  task automatic end_and_latch(input string req);
    cyc_drive(0, 1, 1);
    cyc_drive(0, 0, 0);
    chk_out(req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    bit moved;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk_out("R1 reset");
    rst_n = 1'b1;
    cyc_drive(0, 0, 0);
    chk_out("R1 after release");

    // R4: short silence
    run_interval(STEP - 1, 30);
    end_and_latch("R4 short interval");
    // R4: zero-length
    end_and_latch("R4 empty interval");

    // R2: exact boundary and one short of it
    run_interval(3 * STEP, 0);
    end_and_latch("R2 exact three steps");
    chk("R2 three stages", therm, 8'h07);
    run_interval(5 * STEP - 1, 50);
    end_and_latch("R2 one tick short of five");
    chk("R2 four stages", therm, 8'h0F);

    // R3: saturation
    run_interval(15 * STEP, 20);
    end_and_latch("R3 saturation");
    chk("R3 full scale", therm, 8'hFF);
    run_interval(N * STEP, 0);
    end_and_latch("R3 exact full");

    // R5: brief drop restarts count
    run_interval(5 * STEP + 4, 10);
    cyc_drive(0, 1, 0);
    run_interval(STEP + 3, 10);
    end_and_latch("R5 restart after drop");
    chk("R5 one stage", therm, 8'h01);

    // R6: strobe on the edge where a step completes
    run_interval(3 * STEP - 1, 0);
    cyc_drive(1, 1, 1);
    cyc_drive(1, 0, 0);
    chk_out("R6 pre-edge capture");
    chk("R6 two stages", therm, 8'h03);
    cyc_drive(0, 0, 1);
    cyc_drive(0, 0, 0);
    chk_out("R6 later capture");
    chk("R6 three stages", therm, 8'h07);

    // R7: no latch, output frozen
    held = therm;
    moved = 0;
    run_interval(6 * STEP, 25);
    for (int i = 0; i < 20; i++) begin
      cyc_drive(logic'($urandom % 2), logic'($urandom % 2), 0);
      if (therm !== held) moved = 1;
    end
    cyc_drive(0, 0, 0);
    chk("R7 held code", therm, held);
    chk("R7 no motion", 8'(moved), 8'h00);

    // random intervals
    for (int r = 0; r < 40; r++) begin
      run_interval(int'($urandom % 110), int'($urandom % 70));
      end_and_latch("R2 random interval");
      for (int g = 0; g < int'($urandom % 3); g++) cyc_drive(0, 1, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule